// File: doc/BRIEF.md
# SCSI Bus Controller Register Interface

This block is the host-facing register file of a single-ended SCSI bus port. A processor reaches eight byte-wide registers through a 3-bit address, a write strobe and a read strobe. The stored command bytes are turned into open-drain pad enables for the nine control lines and the eight data lines. The live bus lines are sampled and reported back to the host. The port can behave as an initiator or as a target. Arbitration timing and the DMA handshake are separate blocks. They connect to this one through a few status inputs and start and cancel pulses.

Pad enables are active low. A 0 pulls the line to its asserted level, and a 1 releases it. Control lines use this bit order in both `ctl_drv_n` and `bus_ctl_in`: [8] RST, [7] BSY, [6] SEL, [5] ATN, [4] ACK, [3] REQ, [2] MSG, [1] C/D, [0] I/O. Registers are at these addresses: 0 data, 1 initiator command, 2 mode, 3 target command, 4 bus status, 5 bus-and-transfer status / start send, 6 start target receive, 7 start initiator receive. Writes take effect on the rising clock edge. Reads are combinational while `rd_en` is high, and `rdata` is 0 otherwise.

Top module: `scsi_reg_if`

## Requirements
- R1: After reset every register reads 0, `ctl_drv_n` is 9'h1FF, `data_drv_n` is 8'hFF, and no pulse output is high.
- R2: The data pads carry the inverted data register (address 0) only while initiator-command bit0 is 1. Otherwise `data_drv_n` is 8'hFF.
- R3: In initiator mode (mode bit6 = 0), initiator-command bits drive the lines as follows: bit7 to RST, bit2 to SEL, bit1 to ATN, and bit4 OR `dma_ack_in` to ACK. BSY follows bit3 as last written. REQ, MSG, C/D and I/O stay released, whatever the target command holds.
- R4: In target mode (mode bit6 = 1), target-command bits 3..0 drive REQ, MSG, C/D and I/O respectively. ATN and ACK are released even when `dma_ack_in` is high. RST, SEL and BSY still come from the initiator command.
- R5: While initiator-command bit6 (test mode) is 1, all control and data pads are released.
- R6: A read of address 1 returns the written byte, except that bit6 shows `arb_busy_in` and bit5 shows `arb_lost_in`.
- R7: A read of address 4 returns the live bus in this layout: RST=bit7, BSY=bit6, REQ=bit5, MSG=bit4, C/D=bit3, I/O=bit2, SEL=bit1, parity=bit0.
- R8: A read of address 5 returns bit6 = `dma_req_in`. Bit3 is 1 when target-command bits 2..0 equal the bus MSG, C/D and I/O lines. Bit1 = ATN and bit0 = ACK. All other bits are 0.
- R9: A mode write whose two low bits are 00 releases BSY from the next cycle until bit3 is written to the initiator command again. It also raises `dma_cancel` for exactly one cycle.
- R10: A mode write whose bit1 is 1 clears initiator-command bit0, and with it the data drive.
- R11: Reads of addresses 6 and 7 return 8'hFF. Address 0 returns `bus_data_in`. Addresses 2 and 3 return the written bytes.
- R12: A write to address 5, 6 or 7 raises `dma_start` for one cycle. `dma_kind` is set to 0, 1 or 2 respectively.
- R13: A mode write whose two low bits are 01 raises `arb_start` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| bus_ctl_in | input | 9 | Live control lines, active-high, order above |
| bus_data_in | input | 8 | Live data lines, active-high |
| bus_par_in | input | 1 | Live parity line |
| arb_busy_in | input | 1 | Arbitration in progress, from the arbitration block |
| arb_lost_in | input | 1 | Arbitration lost, from the arbitration block |
| dma_req_in | input | 1 | Transfer request pending, from the DMA block |
| dma_ack_in | input | 1 | Acknowledge request from the DMA block (initiator only) |
| ctl_drv_n | output | 9 | Control pad pull enables, active low |
| data_drv_n | output | 8 | Data pad pull enables, active low |
| mode_out | output | 8 | Current mode register for neighbour blocks |
| arb_start | output | 1 | One-cycle pulse to begin arbitration |
| dma_cancel | output | 1 | One-cycle pulse dropping any pending transfer request |
| dma_start | output | 1 | One-cycle pulse starting a transfer |
| dma_kind | output | 2 | Transfer kind of the last start: 0 send, 1 target receive, 2 initiator receive |

## Verification
Some properties hold on every cycle. Test mode releases every pad. Target mode never pulls ATN or ACK. Initiator mode never pulls the four phase lines. The data pads stay released without the data-enable bit. Mode and start writes always produce their pulses on the next cycle. The bench scenarios are needed for the rest: the exact line mapping for each command pattern, the readback layouts with the substituted arbitration bits, the phase-match compare against a changing bus, and the sticky BSY release that lasts until the initiator command is rewritten.

// File: rtl/scsi_reg_pkg.sv
package scsi_reg_pkg;
    localparam int DW   = 8;
    localparam int AW   = 3;
    localparam int NCTL = 9;
    localparam int KW   = 2;

    // control line bit positions
    localparam int L_IO  = 0;
    localparam int L_CD  = 1;
    localparam int L_MSG = 2;
    localparam int L_REQ = 3;
    localparam int L_ACK = 4;
    localparam int L_ATN = 5;
    localparam int L_SEL = 6;
    localparam int L_BSY = 7;
    localparam int L_RST = 8;

    typedef enum logic [AW-1:0] {
        RA_DATA = 3'd0,
        RA_ICMD = 3'd1,
        RA_MODE = 3'd2,
        RA_TCMD = 3'd3,
        RA_BUS  = 3'd4,
        RA_XFER = 3'd5,
        RA_TRX  = 3'd6,
        RA_IRX  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [DW-1:0] icmd;
        logic [DW-1:0] mode;
        logic [DW-1:0] tcmd;
        logic [DW-1:0] data;
        logic          bsy_hold;
    } regs_t;

    // phase lines MSG, C/D, I/O packed as a 3-bit code
    function automatic logic [2:0] phase_of(input logic [NCTL-1:0] c);
        return {c[L_MSG], c[L_CD], c[L_IO]};
    endfunction
endpackage

// File: rtl/scsi_reg_bank.sv
module scsi_reg_bank
    import scsi_reg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output regs_t           regs,
    output logic            arb_start,
    output logic            dma_cancel,
    output logic            dma_start,
    output logic [KW-1:0]   dma_kind
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs       <= '0;
            arb_start  <= 1'b0;
            dma_cancel <= 1'b0;
            dma_start  <= 1'b0;
            dma_kind   <= '0;
        end else begin
            arb_start  <= 1'b0;
            dma_cancel <= 1'b0;
            dma_start  <= 1'b0;
            if (wr_en) begin
                unique case (reg_addr_e'(addr))
                    RA_DATA: regs.data <= wdata;
                    RA_ICMD: begin
                        regs.icmd     <= wdata;
                        regs.bsy_hold <= wdata[3];
                    end
                    RA_MODE: begin
                        regs.mode <= wdata;
                        if (wdata[1:0] == 2'b00) begin
                            regs.bsy_hold <= 1'b0;
                            dma_cancel    <= 1'b1;
                        end else if (wdata[1:0] == 2'b01) begin
                            arb_start <= 1'b1;
                        end else begin
                            regs.icmd[0] <= 1'b0;
                        end
                    end
                    RA_TCMD: regs.tcmd <= wdata;
                    RA_BUS:  ;
                    default: begin
                        dma_start <= 1'b1;
                        dma_kind  <= KW'(addr[1:0] - 2'd1);
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/scsi_line_drive.sv
module scsi_line_drive
    import scsi_reg_pkg::*;
(
    input  regs_t            regs,
    input  logic             dma_ack_in,
    output logic [NCTL-1:0]  ctl_drv_n,
    output logic [DW-1:0]    data_drv_n
);
    logic [NCTL-1:0] ctl_on;
    logic [DW-1:0]   dat_on;

    always_comb begin
        ctl_on        = '0;
        ctl_on[L_RST] = regs.icmd[7];
        ctl_on[L_BSY] = regs.bsy_hold;
        ctl_on[L_SEL] = regs.icmd[2];
        if (regs.mode[6]) begin
            ctl_on[L_REQ] = regs.tcmd[3];
            ctl_on[L_MSG] = regs.tcmd[2];
            ctl_on[L_CD]  = regs.tcmd[1];
            ctl_on[L_IO]  = regs.tcmd[0];
        end else begin
            ctl_on[L_ATN] = regs.icmd[1];
            ctl_on[L_ACK] = regs.icmd[4] | dma_ack_in;
        end
        dat_on = regs.icmd[0] ? regs.data : '0;
        if (regs.icmd[6]) begin
            ctl_on = '0;
            dat_on = '0;
        end
        ctl_drv_n  = ~ctl_on;
        data_drv_n = ~dat_on;
    end
endmodule

// File: rtl/scsi_rd_mux.sv
module scsi_rd_mux
    import scsi_reg_pkg::*;
(
    input  logic [AW-1:0]   addr,
    input  logic            rd_en,
    input  regs_t           regs,
    input  logic [NCTL-1:0] bus_ctl_in,
    input  logic [DW-1:0]   bus_data_in,
    input  logic            bus_par_in,
    input  logic            arb_busy_in,
    input  logic            arb_lost_in,
    input  logic            dma_req_in,
    output logic [DW-1:0]   rdata
);
    logic phase_eq;
    assign phase_eq = (regs.tcmd[2:0] == phase_of(bus_ctl_in));

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (reg_addr_e'(addr))
                RA_DATA: rdata = bus_data_in;
                RA_ICMD: rdata = {regs.icmd[7], arb_busy_in, arb_lost_in, regs.icmd[4:0]};
                RA_MODE: rdata = regs.mode;
                RA_TCMD: rdata = regs.tcmd;
                RA_BUS:  rdata = {bus_ctl_in[L_RST], bus_ctl_in[L_BSY], bus_ctl_in[L_REQ],
                                  bus_ctl_in[L_MSG], bus_ctl_in[L_CD], bus_ctl_in[L_IO],
                                  bus_ctl_in[L_SEL], bus_par_in};
                RA_XFER: rdata = {1'b0, dma_req_in, 2'b00, phase_eq, 1'b0,
                                  bus_ctl_in[L_ATN], bus_ctl_in[L_ACK]};
                default: rdata = '1;
            endcase
        end
    end
endmodule

// File: rtl/scsi_reg_if.sv
module scsi_reg_if
    import scsi_reg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      addr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic [8:0]      bus_ctl_in,
    input  logic [7:0]      bus_data_in,
    input  logic            bus_par_in,
    input  logic            arb_busy_in,
    input  logic            arb_lost_in,
    input  logic            dma_req_in,
    input  logic            dma_ack_in,
    output logic [8:0]      ctl_drv_n,
    output logic [7:0]      data_drv_n,
    output logic [7:0]      mode_out,
    output logic            arb_start,
    output logic            dma_cancel,
    output logic            dma_start,
    output logic [1:0]      dma_kind
);
    regs_t regs;

    scsi_reg_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .regs(regs), .arb_start(arb_start), .dma_cancel(dma_cancel),
        .dma_start(dma_start), .dma_kind(dma_kind)
    );

    scsi_line_drive u_drive (
        .regs(regs), .dma_ack_in(dma_ack_in),
        .ctl_drv_n(ctl_drv_n), .data_drv_n(data_drv_n)
    );

    scsi_rd_mux u_rd (
        .addr(addr), .rd_en(rd_en), .regs(regs),
        .bus_ctl_in(bus_ctl_in), .bus_data_in(bus_data_in), .bus_par_in(bus_par_in),
        .arb_busy_in(arb_busy_in), .arb_lost_in(arb_lost_in), .dma_req_in(dma_req_in),
        .rdata(rdata)
    );

    assign mode_out = regs.mode;
endmodule

// File: rtl/scsi_reg_if_chk.sv
module scsi_reg_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] icmd,
    input logic [7:0] mode,
    input logic [8:0] ctl_drv_n,
    input logic [7:0] data_drv_n,
    input logic       dma_cancel,
    input logic       dma_start
);
    // R5
    test_release_chk: assert property (@(posedge clk) disable iff (rst)
        icmd[6] |-> (&ctl_drv_n && &data_drv_n));
    // R4
    target_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode[6] |-> (ctl_drv_n[5] && ctl_drv_n[4]));
    // R3
    init_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !mode[6] |-> (&ctl_drv_n[3:0]));
    // R2
    data_release_chk: assert property (@(posedge clk) disable iff (rst)
        !icmd[0] |-> (&data_drv_n));
    // R9
    cancel_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd2 && wdata[1:0] == 2'b00) |=> (dma_cancel && ctl_drv_n[7]));
    // R12
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= 3'd5) |=> dma_start);
endmodule

bind scsi_reg_if scsi_reg_if_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .icmd(regs.icmd), .mode(regs.mode), .ctl_drv_n(ctl_drv_n),
    .data_drv_n(data_drv_n), .dma_cancel(dma_cancel), .dma_start(dma_start)
);

// File: tb/sim_scsi_reg_if.sv
`timescale 1ns/1ps
module sim_scsi_reg_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic [8:0] bus_ctl_in = '0;
    logic [7:0] bus_data_in = '0;
    logic       bus_par_in = 1'b0, arb_busy_in = 1'b0, arb_lost_in = 1'b0;
    logic       dma_req_in = 1'b0, dma_ack_in = 1'b0;
    logic [8:0] ctl_drv_n;
    logic [7:0] data_drv_n, mode_out;
    logic       arb_start, dma_cancel, dma_start;
    logic [1:0] dma_kind;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scsi_reg_if u0 (.*);

    // {mode, icmd, tcmd, data, dma_ack, exp ctl_drv_n, exp data_drv_n}
    localparam int NV = 7;
    localparam logic [49:0] VEC [NV] = '{
        {8'h00, 8'h01, 8'h00, 8'hA5, 1'b0, 9'h1FF, 8'h5A},  // R2 data only
        {8'h00, 8'h9E, 8'h0F, 8'h3C, 1'b0, 9'h00F, 8'hFF},  // R3 initiator lines
        {8'h40, 8'h12, 8'h0A, 8'h00, 1'b0, 9'h1F5, 8'hFF},  // R4 target REQ C/D
        {8'h40, 8'h85, 8'h05, 8'h81, 1'b0, 9'h0BA, 8'h7E},  // R4 target MSG I/O
        {8'h00, 8'h49, 8'h00, 8'h00, 1'b0, 9'h1FF, 8'hFF},  // R5 test mode
        {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 9'h1EF, 8'hFF},  // R3 dma ack
        {8'h40, 8'h00, 8'h00, 8'h00, 1'b1, 9'h1FF, 8'hFF}   // R4 dma ack ignored
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #0.5 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_up();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ctl", 16'(ctl_drv_n), 16'h1FF);
        chk("R1 data", 16'(data_drv_n), 16'hFF);
        chk("R1 pulses", 16'({arb_start, dma_cancel, dma_start}), 16'h0);
        rd(3'd1, v); chk("R1 icmd", 16'(v), 16'h00);
        rd(3'd2, v); chk("R1 mode", 16'(v), 16'h00);
        rd(3'd3, v); chk("R1 tcmd", 16'(v), 16'h00);

        for (int i = 0; i < NV; i++) begin
            dma_ack_in = VEC[i][17];
            wr(3'd0, VEC[i][25:18]);
            wr(3'd3, VEC[i][33:26]);
            wr(3'd2, VEC[i][49:42]);
            wr(3'd1, VEC[i][41:34]);
            chk($sformatf("R2-R5 vec%0d ctl", i), 16'(ctl_drv_n), 16'(VEC[i][16:8]));
            chk($sformatf("R2-R5 vec%0d data", i), 16'(data_drv_n), 16'(VEC[i][7:0]));
        end
        dma_ack_in = 1'b0;

        // R6 arbitration bits substituted
        wr(3'd1, 8'hFF);
        arb_lost_in = 1'b1;
        rd(3'd1, v); chk("R6 lost", 16'(v), 16'hBF);
        arb_busy_in = 1'b1; arb_lost_in = 1'b0;
        rd(3'd1, v); chk("R6 busy", 16'(v), 16'hDF);
        arb_busy_in = 1'b0;

        // R7 bus status layout: RST REQ C/D SEL + parity
        bus_ctl_in = 9'h14A; bus_par_in = 1'b1;
        rd(3'd4, v); chk("R7 bus", 16'(v), 16'hAB);
        bus_par_in = 1'b0;

        // R8 phase match
        wr(3'd3, 8'h06);
        bus_ctl_in = 9'h026; dma_req_in = 1'b1;
        rd(3'd5, v); chk("R8 match", 16'(v), 16'h4A);
        bus_ctl_in = 9'h037;
        rd(3'd5, v); chk("R8 mismatch", 16'(v), 16'h43);
        dma_req_in = 1'b0; bus_ctl_in = '0;

        // R9 BSY release and cancel pulse
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h08);
        chk("R9 bsy on", 16'(ctl_drv_n[7]), 16'h0);
        wr(3'd2, 8'h00);
        chk("R9 cancel", 16'(dma_cancel), 16'h1);
        chk("R9 bsy off", 16'(ctl_drv_n[7]), 16'h1);
        @(negedge clk);
        chk("R9 one cycle", 16'(dma_cancel), 16'h0);
        chk("R9 bsy stays off", 16'(ctl_drv_n[7]), 16'h1);
        rd(3'd1, v); chk("R9 icmd kept", 16'(v), 16'h08);

        // R13 arbitration start
        wr(3'd2, 8'h01);
        chk("R13 arb pulse", 16'({arb_start, dma_cancel}), 16'h2);
        @(negedge clk);
        chk("R13 arb drop", 16'(arb_start), 16'h0);

        // R10 transfer mode clears data enable
        wr(3'd0, 8'h33);
        wr(3'd1, 8'h01);
        chk("R10 pre", 16'(data_drv_n), 16'hCC);
        wr(3'd2, 8'h02);
        chk("R10 data off", 16'(data_drv_n), 16'hFF);
        rd(3'd1, v); chk("R10 icmd", 16'(v), 16'h00);

        // R12 transfer starts
        wr(3'd6, 8'h00);
        chk("R12 trx", 16'({dma_start, dma_kind}), 16'h5);
        wr(3'd7, 8'h00);
        chk("R12 irx", 16'({dma_start, dma_kind}), 16'h6);
        wr(3'd5, 8'h00);
        chk("R12 send", 16'({dma_start, dma_kind}), 16'h4);
        @(negedge clk);
        chk("R12 drop", 16'(dma_start), 16'h0);

        // R11 fixed and live reads
        bus_data_in = 8'h5C;
        rd(3'd0, v); chk("R11 data", 16'(v), 16'h5C);
        rd(3'd2, v); chk("R11 mode", 16'(v), 16'h02);
        chk("R11 mode_out", 16'(mode_out), 16'h02);
        rd(3'd6, v); chk("R11 a6", 16'(v), 16'hFF);
        rd(3'd7, v); chk("R11 a7", 16'(v), 16'hFF);

        done = 1'b1;
        finish_up();
    end
endmodule